// File: doc/BRIEF.md
# Last-Store Predictor

This block sits beside an L1 data cache and guesses, frame by frame, when a dirty block has received its final store before eviction. Once that store is identified, the cache can copy the block to the next level early. The block stays in L1 with its data and permissions, so it is exposed to multi-bit upsets for far less time. If a later write does reach the block, the cache either marks it dirty again or asks again for write permission. All of that is the cache's business and lies outside this block.

Each frame keeps a 16-bit running trace of the program counters that have stored to it since it was last evicted. An eviction uses the finished trace to train a direct-mapped table of signatures, each with a 2-bit confidence counter. Every store is followed by a lookup of the updated trace. A confident hit is taken as a last store, and the block raises a write-back request naming the frame. A per-frame flag records that a prediction was made. If another store reaches a flagged frame, the prediction was wrong and the matching signature's confidence is reduced. The prediction uses only instruction addresses and never data addresses, so one learned trace covers every frame written by the same code path.

Top module: `last_store_predictor`

## Requirements
- R1: Reset (synchronous, active high) empties the request output, sets every frame trace and predicted flag to zero, and sets every confidence counter to zero.
- R2: A store sets its frame's trace to (old trace + low 16 bits of the PC) modulo 2^16. The upper PC bits have no effect.
- R3: An eviction trains on the frame's trace. Table index = trace bits [11:0], tag = bits [15:12]. If the entry holds a different tag, or its counter is 0, the entry is overwritten with the new tag and confidence 2, replacing what was there.
- R4: If the entry already holds the trace's tag with a nonzero counter, training adds one, and the counter stops at 3.
- R5: After every store, the new trace is looked up. A tag match with confidence 2 or more is a prediction. It queues a write-back request for the store's frame, visible on `wb_req`/`wb_frame` in the cycle after the store when the queue is empty, and it sets that frame's predicted flag. Without a prediction, the flag is cleared.
- R6: An entry whose tag differs from the trace's upper four bits never produces a prediction, even when its confidence is high.
- R7: A store to a frame whose predicted flag is set first subtracts one from the counter of the entry matching the old trace. This happens only on a tag match, and the counter stops at 0.
- R8: An eviction sets the frame's trace to zero and clears its predicted flag, so the next store to that frame does not decrement anything.
- R9: When an eviction and a store reach the same frame in one cycle, the eviction (training and clearing) is applied first and the store is applied after it.
- R10: `wb_req` stays high with a fixed `wb_frame` until it is accepted by `wb_ack`. One more prediction is held behind it and is presented next, in arrival order. A prediction made while both slots are full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store to the cache happens this cycle |
| st_frame | input | log2(NUM_FRAMES) | Cache frame written by the store |
| st_pc | input | PC_W | Program counter of the store instruction |
| ev_valid | input | 1 | A frame is evicted this cycle |
| ev_frame | input | log2(NUM_FRAMES) | Cache frame being evicted |
| wb_ack | input | 1 | Cache accepts the current write-back request |
| wb_req | output | 1 | Early write-back requested |
| wb_frame | output | log2(NUM_FRAMES) | Frame to write back |

## Verification
The checker watches the request handshake on every cycle. While a request is waiting it must stay up with an unchanged frame. A buffered request must never appear without a visible head. A prediction made with the queue empty must surface in the next cycle naming the store's frame. A same-frame eviction and store must never trigger a decrement, and reset must leave the output idle. The learning behaviour cannot be seen in a single cycle and needs the bench's scripted sequences to show it. That includes installing at confidence 2, replacing an entry with a different tag, saturating at 3 and at 0, wrapping the trace sum, and the eviction-first rule, where the order decides whether a later trace still predicts.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_ZERO    = '0;
  localparam logic [CONF_W-1:0] CONF_ONE     = {{(CONF_W-1){1'b0}}, 1'b1};
  localparam logic [CONF_W-1:0] CONF_INSTALL = CONF_W'(2);
  localparam logic [CONF_W-1:0] CONF_PREDICT = CONF_W'(2);
  localparam logic [CONF_W-1:0] CONF_MAX     = '1;

  function automatic logic [CONF_W-1:0] conf_up(input logic [CONF_W-1:0] c);
    return (c == CONF_MAX) ? c : c + CONF_ONE;
  endfunction

  function automatic logic [CONF_W-1:0] conf_down(input logic [CONF_W-1:0] c);
    return (c == CONF_ZERO) ? c : c - CONF_ONE;
  endfunction
endpackage

// File: rtl/lsp_history.sv
module lsp_history #(
  parameter int NUM_FRAMES = 64,
  parameter int SIG_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_en,
  input  logic [$clog2(NUM_FRAMES)-1:0] clr_frame,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_FRAMES)-1:0] wr_frame,
  input  logic [SIG_W-1:0]              wr_trace,
  input  logic                          wr_pred,
  output logic [SIG_W-1:0]              clr_trace,
  output logic [SIG_W-1:0]              rd_trace,
  output logic                          rd_pred
);
  logic [SIG_W-1:0] trace_q [NUM_FRAMES];
  logic             pred_q  [NUM_FRAMES];

  assign clr_trace = trace_q[clr_frame];
  assign rd_trace  = trace_q[wr_frame];
  assign rd_pred   = pred_q[wr_frame];

  // The store write comes after the clear, so a same-frame store wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_FRAMES; i++) begin
        trace_q[i] <= '0;
        pred_q[i]  <= 1'b0;
      end
    end else begin
      if (clr_en) begin
        trace_q[clr_frame] <= '0;
        pred_q[clr_frame]  <= 1'b0;
      end
      if (wr_en) begin
        trace_q[wr_frame] <= wr_trace;
        pred_q[wr_frame]  <= wr_pred;
      end
    end
  end
endmodule

// File: rtl/lsp_sig_table.sv
module lsp_sig_table
  import lsp_pkg::*;
#(
  parameter int SIG_W  = 16,
  parameter int TBL_AW = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             train_en,
  input  logic [SIG_W-1:0] train_sig,
  input  logic             dec_req,
  input  logic [SIG_W-1:0] dec_sig,
  input  logic [SIG_W-1:0] look_sig,
  output logic             look_hit
);
  localparam int TAG_W = SIG_W - TBL_AW;
  localparam int DEPTH = 1 << TBL_AW;

  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [CONF_W-1:0] conf_q [DEPTH];

  logic [TBL_AW-1:0] t_idx, d_idx, l_idx;
  logic [TAG_W-1:0]  t_tag, d_tag, l_tag, d_tag_cur, l_tag_cur;
  logic [CONF_W-1:0] t_conf_new, d_conf_cur, d_conf_new, l_conf_cur;
  logic              t_present, d_match;

  assign t_idx = train_sig[TBL_AW-1:0];
  assign t_tag = train_sig[SIG_W-1:TBL_AW];
  assign d_idx = dec_sig[TBL_AW-1:0];
  assign d_tag = dec_sig[SIG_W-1:TBL_AW];
  assign l_idx = look_sig[TBL_AW-1:0];
  assign l_tag = look_sig[SIG_W-1:TBL_AW];

  // Training (applied first)
  always_comb begin
    t_present  = (tag_q[t_idx] == t_tag) && (conf_q[t_idx] != CONF_ZERO);
    t_conf_new = t_present ? conf_up(conf_q[t_idx]) : CONF_INSTALL;
  end

  // Misprediction penalty sees the result of training
  always_comb begin
    d_tag_cur  = tag_q[d_idx];
    d_conf_cur = conf_q[d_idx];
    if (train_en && (t_idx == d_idx)) begin
      d_tag_cur  = t_tag;
      d_conf_cur = t_conf_new;
    end
    d_match    = dec_req && (d_tag_cur == d_tag) && (d_conf_cur != CONF_ZERO);
    d_conf_new = conf_down(d_conf_cur);
  end

  // Lookup sees both earlier updates
  always_comb begin
    l_tag_cur  = tag_q[l_idx];
    l_conf_cur = conf_q[l_idx];
    if (train_en && (t_idx == l_idx)) begin
      l_tag_cur  = t_tag;
      l_conf_cur = t_conf_new;
    end
    if (d_match && (d_idx == l_idx)) l_conf_cur = d_conf_new;
    look_hit = (l_tag_cur == l_tag) && (l_conf_cur >= CONF_PREDICT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= '0;
        conf_q[i] <= CONF_ZERO;
      end
    end else begin
      if (train_en) begin
        tag_q[t_idx]  <= t_tag;
        conf_q[t_idx] <= t_conf_new;
      end
      if (d_match) conf_q[d_idx] <= d_conf_new;
    end
  end
endmodule

// File: rtl/lsp_wb_queue.sv
module lsp_wb_queue #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             ack,
  output logic             req,
  output logic [IDX_W-1:0] req_idx,
  output logic             buf_valid
);
  logic             head_v, buf_v, n_head_v, n_buf_v;
  logic [IDX_W-1:0] head_i, buf_i, n_head_i, n_buf_i;

  always_comb begin
    n_head_v = head_v;
    n_head_i = head_i;
    n_buf_v  = buf_v;
    n_buf_i  = buf_i;
    if (head_v && ack) begin
      n_head_v = buf_v;
      n_head_i = buf_i;
      n_buf_v  = 1'b0;
    end
    if (push) begin
      if (!n_head_v) begin
        n_head_v = 1'b1;
        n_head_i = push_idx;
      end else if (!n_buf_v) begin
        n_buf_v = 1'b1;
        n_buf_i = push_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_v <= 1'b0;
      buf_v  <= 1'b0;
      head_i <= '0;
      buf_i  <= '0;
    end else begin
      head_v <= n_head_v;
      buf_v  <= n_buf_v;
      head_i <= n_head_i;
      buf_i  <= n_buf_i;
    end
  end

  assign req       = head_v;
  assign req_idx   = head_i;
  assign buf_valid = buf_v;
endmodule

// File: rtl/last_store_predictor.sv
module last_store_predictor #(
  parameter int NUM_FRAMES = 64,
  parameter int PC_W       = 32,
  parameter int SIG_W      = 16,
  parameter int TBL_AW     = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          st_valid,
  input  logic [$clog2(NUM_FRAMES)-1:0] st_frame,
  input  logic [PC_W-1:0]               st_pc,
  input  logic                          ev_valid,
  input  logic [$clog2(NUM_FRAMES)-1:0] ev_frame,
  input  logic                          wb_ack,
  output logic                          wb_req,
  output logic [$clog2(NUM_FRAMES)-1:0] wb_frame
);
  localparam int FRAME_W = $clog2(NUM_FRAMES);

  logic [SIG_W-1:0] ev_trace, rd_trace, old_trace, new_trace;
  logic             rd_pred, old_pred, same_frame;
  logic             dec_req, look_hit, pred_fire, buf_valid;
  logic             unused_pc_hi;

  generate
    if (PC_W > SIG_W) begin : g_pc_wide
      assign unused_pc_hi = ^st_pc[PC_W-1:SIG_W];
    end else begin : g_pc_narrow
      assign unused_pc_hi = 1'b0;
    end
  endgenerate

  // A same-cycle eviction of the stored frame is seen as already done.
  assign same_frame = ev_valid && (ev_frame == st_frame);
  assign old_trace  = same_frame ? '0 : rd_trace;
  assign old_pred   = same_frame ? 1'b0 : rd_pred;
  assign new_trace  = old_trace + st_pc[SIG_W-1:0];
  assign dec_req    = st_valid && old_pred;
  assign pred_fire  = st_valid && look_hit;

  lsp_history #(.NUM_FRAMES(NUM_FRAMES), .SIG_W(SIG_W)) u_hist (
    .clk(clk), .rst(rst),
    .clr_en(ev_valid), .clr_frame(ev_frame),
    .wr_en(st_valid), .wr_frame(st_frame),
    .wr_trace(new_trace), .wr_pred(pred_fire),
    .clr_trace(ev_trace), .rd_trace(rd_trace), .rd_pred(rd_pred)
  );

  lsp_sig_table #(.SIG_W(SIG_W), .TBL_AW(TBL_AW)) u_sig (
    .clk(clk), .rst(rst),
    .train_en(ev_valid), .train_sig(ev_trace),
    .dec_req(dec_req), .dec_sig(old_trace),
    .look_sig(new_trace), .look_hit(look_hit)
  );

  lsp_wb_queue #(.IDX_W(FRAME_W)) u_q (
    .clk(clk), .rst(rst),
    .push(pred_fire), .push_idx(st_frame), .ack(wb_ack),
    .req(wb_req), .req_idx(wb_frame), .buf_valid(buf_valid)
  );
endmodule

// File: rtl/last_store_predictor_chk.sv
module last_store_predictor_chk #(
  parameter int NUM_FRAMES = 64
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          st_valid,
  input logic [$clog2(NUM_FRAMES)-1:0] st_frame,
  input logic                          ev_valid,
  input logic [$clog2(NUM_FRAMES)-1:0] ev_frame,
  input logic                          wb_ack,
  input logic                          wb_req,
  input logic [$clog2(NUM_FRAMES)-1:0] wb_frame,
  input logic                          pred_fire,
  input logic                          dec_req,
  input logic                          buf_valid
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !wb_req);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wb_req && !wb_ack |=> wb_req && $stable(wb_frame));

  // R10
  req_drain_chk: assert property (@(posedge clk) disable iff (rst)
    wb_req && wb_ack && !buf_valid && !pred_fire |=> !wb_req);

  // R10
  buf_order_chk: assert property (@(posedge clk) disable iff (rst)
    buf_valid |-> wb_req);

  // R5
  pred_issue_chk: assert property (@(posedge clk) disable iff (rst)
    pred_fire && !wb_req |=> wb_req && (wb_frame == $past(st_frame)));

  // R9
  evict_first_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid && st_valid && (ev_frame == st_frame) |-> !dec_req);
endmodule

bind last_store_predictor last_store_predictor_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_frame(st_frame),
  .ev_valid(ev_valid), .ev_frame(ev_frame), .wb_ack(wb_ack),
  .wb_req(wb_req), .wb_frame(wb_frame), .pred_fire(pred_fire),
  .dec_req(dec_req), .buf_valid(buf_valid)
);

// File: tb/last_store_predictor_bench.sv
`timescale 1ns/1ps
module last_store_predictor_bench;
  localparam int NF = 8;
  localparam int FW = 3;
  localparam int DEPTH = 4096;

  logic          clk = 1'b0;
  logic          rst, st_valid, ev_valid, wb_ack;
  logic [FW-1:0] st_frame, ev_frame;
  logic [31:0]   st_pc;
  logic          wb_req;
  logic [FW-1:0] wb_frame;

  int n_tests = 0;
  int n_fail  = 0;
  logic ack_lvl = 1'b1;

  // model state
  logic [15:0] m_trace [NF];
  logic        m_pred  [NF];
  logic [3:0]  m_tag   [DEPTH];
  logic [1:0]  m_conf  [DEPTH];
  logic        mh_v, mb_v;
  int          mh, mb;

  always #2 clk = ~clk;

  last_store_predictor #(.NUM_FRAMES(NF), .PC_W(32), .SIG_W(16), .TBL_AW(12)) u_last_store_predictor (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_frame(st_frame), .st_pc(st_pc),
    .ev_valid(ev_valid), .ev_frame(ev_frame), .wb_ack(wb_ack),
    .wb_req(wb_req), .wb_frame(wb_frame)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NF; i++) begin m_trace[i] = '0; m_pred[i] = 1'b0; end
    for (int i = 0; i < DEPTH; i++) begin m_tag[i] = '0; m_conf[i] = '0; end
    mh_v = 1'b0; mb_v = 1'b0; mh = 0; mb = 0;
  endtask

  task automatic model_edge(input bit ev, input int evf, input bit st, input int stf,
                            input logic [31:0] pc, input bit ack);
    bit pop, hit;
    logic [15:0] ot, nt;
    bit op;
    int ix;
    pop = mh_v && ack;
    hit = 1'b0;
    if (ev) begin
      ix = int'(m_trace[evf][11:0]);
      if (m_tag[ix] == m_trace[evf][15:12] && m_conf[ix] != 0)
        m_conf[ix] = (m_conf[ix] == 3) ? 2'd3 : m_conf[ix] + 2'd1;
      else begin
        m_tag[ix] = m_trace[evf][15:12];
        m_conf[ix] = 2'd2;
      end
      m_trace[evf] = '0;
      m_pred[evf] = 1'b0;
    end
    if (st) begin
      ot = m_trace[stf];
      op = m_pred[stf];
      if (op) begin
        ix = int'(ot[11:0]);
        if (m_tag[ix] == ot[15:12] && m_conf[ix] != 0) m_conf[ix] = m_conf[ix] - 2'd1;
      end
      nt = ot + pc[15:0];
      ix = int'(nt[11:0]);
      hit = (m_tag[ix] == nt[15:12]) && (m_conf[ix] >= 2);
      m_trace[stf] = nt;
      m_pred[stf] = hit;
    end
    if (pop) begin mh_v = mb_v; mh = mb; mb_v = 1'b0; end
    if (hit) begin
      if (!mh_v) begin mh_v = 1'b1; mh = stf; end
      else if (!mb_v) begin mb_v = 1'b1; mb = stf; end
    end
  endtask

  task automatic cycle(input bit ev, input int evf, input bit st, input int stf, input logic [31:0] pc);
    @(negedge clk);
    ev_valid = ev; ev_frame = FW'(evf);
    st_valid = st; st_frame = FW'(stf); st_pc = pc;
    wb_ack = ack_lvl;
    @(posedge clk);
    model_edge(ev, evf, st, stf, pc, ack_lvl);
    #1;
    // R10 R5: port view matches the requirement model every cycle
    check((wb_req === mh_v) && (!mh_v || (int'(wb_frame) == mh)), "R10 model request",
          wb_req ? int'(wb_frame) : -1, mh_v ? mh : -1);
  endtask

  task automatic store(input int f, input logic [31:0] pc);
    cycle(1'b0, 0, 1'b1, f, pc);
  endtask
  task automatic evict(input int f);
    cycle(1'b1, f, 1'b0, 0, 32'h0);
  endtask
  task automatic idle();
    cycle(1'b0, 0, 1'b0, 0, 32'h0);
  endtask
  task automatic seq3(input int f);
    store(f, 32'h100); store(f, 32'h200); store(f, 32'h340);
  endtask
  task automatic expect_req(input int f, input string tag);
    int act;
    act = wb_req ? int'(wb_frame) : -1;
    check(act == f, tag, act, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pcs [6];
    void'($urandom(32'h5eed_1234));
    pcs[0] = 32'h100; pcs[1] = 32'h200; pcs[2] = 32'h340;
    pcs[3] = 32'h10;  pcs[4] = 32'h1000; pcs[5] = 32'hABCD_0640;
    rst = 1'b1; st_valid = 1'b0; ev_valid = 1'b0; wb_ack = 1'b1;
    st_frame = '0; ev_frame = '0; st_pc = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    expect_req(-1, "R1 idle after reset");

    // train trace 0x640 (from zero trace, R1/R3)
    seq3(0);
    evict(0);
    store(1, 32'h100);
    expect_req(-1, "R5 partial trace no hit");
    store(1, 32'h200); store(1, 32'h340);
    expect_req(1, "R5 predicted on trained trace");
    store(1, 32'h10);
    expect_req(-1, "R7 store after prediction");
    seq3(2);
    expect_req(-1, "R7 decremented to 1 no predict");
    evict(2);
    seq3(3);
    expect_req(3, "R4 increment restores prediction");
    evict(3);
    seq3(4);
    evict(4);
    seq3(5);
    store(5, 32'h10);
    seq3(6);
    expect_req(6, "R4 saturated at 3 survives one decrement");
    store(6, 32'h10);
    seq3(7);
    expect_req(-1, "R7 two decrements drop below threshold");

    // tag mismatch and replacement
    store(0, 32'h1000); store(0, 32'h640);
    expect_req(-1, "R6 same index other tag no predict");
    evict(0);
    seq3(2);
    expect_req(-1, "R3 old tag replaced");
    store(3, 32'h1000); store(3, 32'h640);
    expect_req(3, "R6 new tag predicts");

    // truncated sum, upper PC bits ignored
    store(4, 32'hFFFF_F800); store(4, 32'h0000_1E40);
    expect_req(4, "R2 wrapped trace predicts");

    // same cycle eviction and store on frame 3 (predicted flag set)
    cycle(1'b1, 3, 1'b1, 3, 32'h1640);
    expect_req(3, "R9 eviction applied before store");

    // eviction clears the predicted flag
    evict(4);
    store(4, 32'h1640);
    expect_req(4, "R8 fresh frame predicts");
    store(4, 32'h10);
    evict(5);
    store(5, 32'h1640);
    expect_req(5, "R8 no decrement after eviction");

    // request queue
    evict(1); evict(6);
    idle();
    expect_req(-1, "R10 queue empty");
    ack_lvl = 1'b0;
    store(0, 32'h1640);
    store(1, 32'h1640);
    store(6, 32'h1640);
    expect_req(0, "R10 head held without ack");
    ack_lvl = 1'b1;
    idle();
    expect_req(1, "R10 buffered request next in order");
    idle();
    expect_req(-1, "R10 third request dropped");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit ev, st;
      ack_lvl = ($urandom_range(0, 3) != 0);
      ev = ($urandom_range(0, 5) == 0);
      st = ($urandom_range(0, 2) != 0);
      cycle(ev, int'($urandom_range(0, NF-1)), st, int'($urandom_range(0, NF-1)),
            pcs[$urandom_range(0, 5)]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule